// File: doc/BRIEF.md
# ACPI Embedded-Controller Command Port

This block is the host-facing end of an embedded controller's ACPI command and data port pair. The host writes command bytes to the command port and address or value bytes to the data port. It polls an eight-bit status byte to know when the block has taken a byte and when a result byte is ready. Five commands are recognised: read a byte of the ACPI memory space, write a byte of it, enter burst mode, leave burst mode, and pop the next pending host event.

The ACPI memory space holds a version byte, a test byte with an automatic complement, a set of general read/write registers, and a read-only window onto an internal mapped-data array. Controller-side logic fills that array through its own write port. A bank of pending host events is set by per-bit pulses from internal sources. The host drains it with the query command, one event at a time, lowest bit first. Burst mode holds off controller-side updates of multi-byte mapped values, so the host reads a consistent set while it issues several commands back to back.

The sequencer has eight named states. `ST_IDLE` waits for a command. `ST_DECODE` acts on the latched command code. `ST_RD_ADDR` waits for a read address and `ST_RD_FETCH` loads the result byte. `ST_WR_ADDR` waits for a write address and `ST_WR_ADDR_ACK` acknowledges it. `ST_WR_DATA` waits for the value and `ST_WR_COMMIT` stores it. The transitions are:
- A command byte accepted in any state goes to `ST_DECODE`.
- From `ST_DECODE`, a read goes to `ST_RD_ADDR` and a write goes to `ST_WR_ADDR`. Every other code goes to `ST_IDLE`.
- An accepted data byte moves `ST_RD_ADDR` to `ST_RD_FETCH`, `ST_WR_ADDR` to `ST_WR_ADDR_ACK` and `ST_WR_DATA` to `ST_WR_COMMIT`.
- `ST_WR_ADDR_ACK` always goes to `ST_WR_DATA`.
- `ST_RD_FETCH` and `ST_WR_COMMIT` always return to `ST_IDLE`.

Top module: `acpi_ec_port`

## Requirements
- R1: Command byte 0x80 starts a read, 0x81 starts a write, 0x82 enters burst mode, 0x83 leaves burst mode and 0x84 pops an event. Any other code returns the block to idle and changes nothing else. A command byte is taken whenever the input-busy flag is clear, and it aborts any sequence in progress.
- R2: Status bit 1 (input busy) is high for exactly the one cycle after an accepted command or data byte. Status bit 3 goes to 1 after an accepted command byte and to 0 after an accepted data byte. After a read address is accepted, status bit 0 (output ready) rises two clock edges after the data write, with the addressed byte on the read-data output. A host read pulse clears status bit 0. All status bits and the read data are 0 after reset.
- R3: A write takes the address byte from the first data-port write and the value from the second. The second byte is accepted only after the busy flag has cleared again, and the value is stored two edges after it is accepted.
- R4: Event pop returns the 1-based index of the lowest set pending bit (bit 0 gives 1, bit 31 gives 32) as the result byte with output ready, and clears that bit. It returns 0 when no event is pending.
- R5: If an event source pulses a bit in the same cycle that a pop clears that bit, the bit stays pending.
- R6: Status bit 5 is the OR of all pending event bits and falls when a pop empties the set.
- R7: Status bit 4 shows burst mode. Status bit 2 is high whenever the sequencer is not idle.
- R8: While burst mode is on, a controller-side mapped write flagged as part of a multi-byte value is refused and `map_held` is raised. Single-byte mapped writes still land, and after burst mode ends multi-byte writes land again.
- R9: ACPI address 0x00 reads the version value 2 and ignores host writes.
- R10: A host write of v to address 0x01 stores v there and sets address 0x02 to 0xFF minus v. Host writes to 0x02 are ignored.
- R11: ACPI addresses 0x20 to 0xFF read mapped-array offsets 0x00 to 0xDF. Host writes to them are ignored.
- R12: A data-port write when no command expects data is ignored: the status byte does not change.
- R13: Addresses 0x03 to 0x13 are general read/write registers that reset to 0. Addresses 0x14 to 0x1F read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_cmd_wr | input | 1 | Host writes `host_wdata` to the command port |
| host_data_wr | input | 1 | Host writes `host_wdata` to the data port |
| host_data_rd | input | 1 | Host reads the data port (clears output ready) |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Result byte for the host |
| host_status | output | 8 | Status: bit0 output ready, bit1 input busy, bit2 processing, bit3 last byte was a command, bit4 burst, bit5 event pending |
| evt_set | input | EVT_W | Per-bit pulses that set pending host events |
| map_we | input | 1 | Controller-side mapped-array write strobe |
| map_addr | input | 8 | Mapped-array offset |
| map_wdata | input | 8 | Mapped-array write byte |
| map_multi | input | 1 | Write belongs to a multi-byte value |
| map_held | output | 1 | Multi-byte write refused because burst mode is on |

## Verification
Two pairs of functions can fall in the same cycle. An event pop and an event source can hit the same bit together. The bench provokes this by pulsing the lowest pending bit during the decode cycle of a query. It then expects that query to return the bit's index while the bit stays pending, so a second query returns the same index again. The second pair is a burst-mode change and a controller-side mapped write. A cycle-accurate behavioural model predicts which of the two wins, and each affected mapped byte is read back over the host port.

// File: rtl/acpi_ec_pkg.sv
package acpi_ec_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECODE,
        ST_RD_ADDR,
        ST_RD_FETCH,
        ST_WR_ADDR,
        ST_WR_ADDR_ACK,
        ST_WR_DATA,
        ST_WR_COMMIT
    } ec_state_t;

    localparam logic [7:0] OP_READ      = 8'h80;
    localparam logic [7:0] OP_WRITE     = 8'h81;
    localparam logic [7:0] OP_BURST_ON  = 8'h82;
    localparam logic [7:0] OP_BURST_OFF = 8'h83;
    localparam logic [7:0] OP_QUERY     = 8'h84;

    localparam int STS_OUT_READY = 0;
    localparam int STS_IN_BUSY   = 1;
    localparam int STS_PROC      = 2;
    localparam int STS_LAST_CMD  = 3;
    localparam int STS_BURST     = 4;
    localparam int STS_EVENT     = 5;

    localparam logic [7:0] ADDR_VERSION = 8'h00;
    localparam logic [7:0] ADDR_TEST    = 8'h01;
    localparam logic [7:0] ADDR_COMPL   = 8'h02;

endpackage

// File: rtl/acpi_ec_events.sv
module acpi_ec_events #(
    parameter int EVT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_W-1:0] set_i,
    input  logic             pop_i,
    output logic [EVT_W-1:0] pending_o,
    output logic [7:0]       idx_o,
    output logic             any_o
);

    logic [EVT_W-1:0] pend_q;
    logic [EVT_W-1:0] lowest;

    // isolate lowest set bit
    assign lowest = pend_q & (~pend_q + EVT_W'(1));

    // 1-based index of the lowest pending bit, 0 when empty
    always_comb begin
        idx_o = 8'd0;
        for (int i = EVT_W - 1; i >= 0; i--) begin
            if (pend_q[i]) idx_o = 8'(i + 1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            // a new pulse beats a pop of the same bit
            pend_q <= (pend_q & ~(pop_i ? lowest : '0)) | set_i;
        end
    end

    assign pending_o = pend_q;
    assign any_o     = |pend_q;

endmodule

// File: rtl/acpi_ec_space.sv
module acpi_ec_space #(
    parameter int NUM_RW    = 17,
    parameter int MAP_DEPTH = 224,
    parameter int MAP_BASE  = 32,
    parameter int VERSION   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] addr_i,
    output logic [7:0] rd_o,
    input  logic       host_we_i,
    input  logic [7:0] host_wval_i,
    input  logic       burst_i,
    input  logic       map_we_i,
    input  logic [7:0] map_addr_i,
    input  logic [7:0] map_wdata_i,
    input  logic       map_multi_i,
    output logic       map_held_o
);
    import acpi_ec_pkg::*;

    localparam int RW_BASE = 3;
    localparam int RW_AW   = (NUM_RW > 1) ? $clog2(NUM_RW) : 1;
    localparam int MAP_AW  = (MAP_DEPTH > 1) ? $clog2(MAP_DEPTH) : 1;
    localparam logic [8:0] RW_LO  = 9'(RW_BASE);
    localparam logic [8:0] RW_HI  = 9'(RW_BASE + NUM_RW);
    localparam logic [8:0] MAP_LO = 9'(MAP_BASE);
    localparam logic [8:0] MAP_HI = 9'(MAP_BASE + MAP_DEPTH);

    logic [7:0] test_q;
    logic [7:0] compl_q;
    logic [7:0] rw_q  [NUM_RW];
    logic [7:0] map_q [MAP_DEPTH];

    logic [8:0] a9;
    logic       in_rw;
    logic       in_map;
    logic       map_ok;

    assign a9     = {1'b0, addr_i};
    assign in_rw  = (a9 >= RW_LO) && (a9 < RW_HI);
    assign in_map = (a9 >= MAP_LO) && (a9 < MAP_HI);

    // test byte and its complement
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            test_q  <= 8'h00;
            compl_q <= 8'hFF;
        end else if (host_we_i && addr_i == ADDR_TEST) begin
            test_q  <= host_wval_i;
            compl_q <= 8'hFF - host_wval_i;
        end
    end

    // general host registers
    generate
        for (genvar g = 0; g < NUM_RW; g++) begin : g_rw
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    rw_q[g] <= 8'h00;
                end else if (host_we_i && a9 == 9'(RW_BASE + g)) begin
                    rw_q[g] <= host_wval_i;
                end
            end
        end
    endgenerate

    // controller-side mapped array; multi-byte updates wait out burst mode
    assign map_ok     = map_we_i && !(burst_i && map_multi_i) &&
                        ({1'b0, map_addr_i} < 9'(MAP_DEPTH));
    assign map_held_o = map_we_i && map_multi_i && burst_i;

    generate
        for (genvar m = 0; m < MAP_DEPTH; m++) begin : g_map
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    map_q[m] <= 8'h00;
                end else if (map_ok && {1'b0, map_addr_i} == 9'(m)) begin
                    map_q[m] <= map_wdata_i;
                end
            end
        end
    endgenerate

    always_comb begin
        rd_o = 8'h00;
        if (addr_i == ADDR_VERSION) begin
            rd_o = 8'(VERSION);
        end else if (addr_i == ADDR_TEST) begin
            rd_o = test_q;
        end else if (addr_i == ADDR_COMPL) begin
            rd_o = compl_q;
        end else if (in_rw) begin
            rd_o = rw_q[RW_AW'(a9 - RW_LO)];
        end else if (in_map) begin
            rd_o = map_q[MAP_AW'(a9 - MAP_LO)];
        end
    end

endmodule

// File: rtl/acpi_ec_ctrl.sv
module acpi_ec_ctrl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wr_i,
    input  logic       data_wr_i,
    input  logic       data_rd_i,
    input  logic [7:0] wdata_i,
    input  logic [7:0] query_idx_i,
    input  logic [7:0] rd_byte_i,
    output logic       obf_o,
    output logic       ibf_o,
    output logic       busy_o,
    output logic       last_cmd_o,
    output logic       burst_o,
    output logic [7:0] rdata_o,
    output logic [7:0] addr_o,
    output logic [7:0] wval_o,
    output logic       wr_en_o,
    output logic       pop_o
);
    import acpi_ec_pkg::*;

    ec_state_t  state_q, state_d;
    logic [7:0] cmd_q, addr_q, val_q, rdata_q;
    logic       ibf_q, obf_q, last_q, burst_q;
    logic       acc_cmd, acc_data, wants_data, load_out;

    assign wants_data = (state_q == ST_RD_ADDR) || (state_q == ST_WR_ADDR) ||
                        (state_q == ST_WR_DATA);
    assign acc_cmd    = cmd_wr_i && !ibf_q;
    assign acc_data   = data_wr_i && !ibf_q && !cmd_wr_i && wants_data;
    assign pop_o      = (state_q == ST_DECODE) && (cmd_q == OP_QUERY);
    assign load_out   = pop_o || (state_q == ST_RD_FETCH);

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (acc_cmd) begin
            state_d = ST_DECODE;
        end else begin
            unique case (state_q)
                ST_IDLE:        state_d = ST_IDLE;
                ST_DECODE: begin
                    if (cmd_q == OP_READ)       state_d = ST_RD_ADDR;
                    else if (cmd_q == OP_WRITE) state_d = ST_WR_ADDR;
                    else                        state_d = ST_IDLE;
                end
                ST_RD_ADDR:     if (acc_data) state_d = ST_RD_FETCH;
                ST_RD_FETCH:    state_d = ST_IDLE;
                ST_WR_ADDR:     if (acc_data) state_d = ST_WR_ADDR_ACK;
                ST_WR_ADDR_ACK: state_d = ST_WR_DATA;
                ST_WR_DATA:     if (acc_data) state_d = ST_WR_COMMIT;
                ST_WR_COMMIT:   state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= 8'h00;
            addr_q  <= 8'h00;
            val_q   <= 8'h00;
            rdata_q <= 8'h00;
            ibf_q   <= 1'b0;
            obf_q   <= 1'b0;
            last_q  <= 1'b0;
            burst_q <= 1'b0;
        end else begin
            ibf_q <= acc_cmd || acc_data;
            if (acc_cmd) begin
                cmd_q  <= wdata_i;
                last_q <= 1'b1;
            end else if (acc_data) begin
                last_q <= 1'b0;
                if (state_q == ST_WR_DATA) val_q  <= wdata_i;
                else                       addr_q <= wdata_i;
            end
            if (state_q == ST_DECODE) begin
                if (cmd_q == OP_BURST_ON)  burst_q <= 1'b1;
                if (cmd_q == OP_BURST_OFF) burst_q <= 1'b0;
            end
            if (load_out) begin
                obf_q   <= 1'b1;
                rdata_q <= pop_o ? query_idx_i : rd_byte_i;
            end else if (data_rd_i) begin
                obf_q <= 1'b0;
            end
        end
    end

    assign obf_o      = obf_q;
    assign ibf_o      = ibf_q;
    assign busy_o     = (state_q != ST_IDLE);
    assign last_cmd_o = last_q;
    assign burst_o    = burst_q;
    assign rdata_o    = rdata_q;
    assign addr_o     = addr_q;
    assign wval_o     = val_q;
    assign wr_en_o    = (state_q == ST_WR_COMMIT);

endmodule

// File: rtl/acpi_ec_port.sv
module acpi_ec_port #(
    parameter int EVT_W     = 32,
    parameter int NUM_RW    = 17,
    parameter int MAP_DEPTH = 224
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_cmd_wr,
    input  logic             host_data_wr,
    input  logic             host_data_rd,
    input  logic [7:0]       host_wdata,
    output logic [7:0]       host_rdata,
    output logic [7:0]       host_status,
    input  logic [EVT_W-1:0] evt_set,
    input  logic             map_we,
    input  logic [7:0]       map_addr,
    input  logic [7:0]       map_wdata,
    input  logic             map_multi,
    output logic             map_held
);
    import acpi_ec_pkg::*;

    logic [7:0]       q_idx, rd_byte, addr, wval;
    logic [EVT_W-1:0] pending;
    logic             ev_any, pop, wr_en;
    logic             obf, ibf, busy, last_cmd, burst;

    acpi_ec_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_wr_i   (host_cmd_wr),
        .data_wr_i  (host_data_wr),
        .data_rd_i  (host_data_rd),
        .wdata_i    (host_wdata),
        .query_idx_i(q_idx),
        .rd_byte_i  (rd_byte),
        .obf_o      (obf),
        .ibf_o      (ibf),
        .busy_o     (busy),
        .last_cmd_o (last_cmd),
        .burst_o    (burst),
        .rdata_o    (host_rdata),
        .addr_o     (addr),
        .wval_o     (wval),
        .wr_en_o    (wr_en),
        .pop_o      (pop)
    );

    acpi_ec_events #(.EVT_W(EVT_W)) u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (evt_set),
        .pop_i    (pop),
        .pending_o(pending),
        .idx_o    (q_idx),
        .any_o    (ev_any)
    );

    acpi_ec_space #(.NUM_RW(NUM_RW), .MAP_DEPTH(MAP_DEPTH)) u_space (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (addr),
        .rd_o       (rd_byte),
        .host_we_i  (wr_en),
        .host_wval_i(wval),
        .burst_i    (burst),
        .map_we_i   (map_we),
        .map_addr_i (map_addr),
        .map_wdata_i(map_wdata),
        .map_multi_i(map_multi),
        .map_held_o (map_held)
    );

    always_comb begin
        host_status                = 8'h00;
        host_status[STS_OUT_READY] = obf;
        host_status[STS_IN_BUSY]   = ibf;
        host_status[STS_PROC]      = busy;
        host_status[STS_LAST_CMD]  = last_cmd;
        host_status[STS_BURST]     = burst;
        host_status[STS_EVENT]     = ev_any;
    end

endmodule

// File: rtl/acpi_ec_port_chk.sv
module acpi_ec_port_chk #(
    parameter int EVT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_wr,
    input logic             data_wr,
    input logic [7:0]       status,
    input logic [EVT_W-1:0] evt_set,
    input logic [EVT_W-1:0] pending
);

    // R2: an accepted command raises busy and the last-was-command flag
    a_r2_cmd_marks: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !status[1]) |=> (status[1] && status[3]));

    // R2: busy lasts a single cycle
    a_r2_busy_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        status[1] |=> !status[1]);

    // R2: output ready only rises out of a command sequence
    a_r2_ready_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[0]) |-> $past(status[2]));

    // R12: data byte while idle is not taken
    a_r12_idle_data: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !cmd_wr && !status[2] && !status[1]) |=> !status[1]);

    // R7: burst flag only changes after a decoded command
    a_r7_burst_from_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[4]) |-> $past(status[2]));

    // R5: a pulsed event is pending on the next cycle whatever the pop did
    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_set) |=> ((pending & $past(evt_set)) == $past(evt_set)));

    // R4: a pop removes at most one event
    a_r4_single_pop: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(evt_set) == '0) |-> ($countones(pending) + 1 >= $countones($past(pending))));

endmodule

bind acpi_ec_port acpi_ec_port_chk #(.EVT_W(EVT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd_wr (host_cmd_wr),
    .data_wr(host_data_wr),
    .status (host_status),
    .evt_set(evt_set),
    .pending(u_evt.pending_o)
);

// File: tb/acpi_ec_port_test.sv
module acpi_ec_port_test;

    localparam int CLK_PERIOD = 10;
    localparam int EW = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_cmd_wr = 1'b0, host_data_wr = 1'b0, host_data_rd = 1'b0;
    logic [7:0]  host_wdata = 8'h00;
    logic [7:0]  host_rdata, host_status;
    logic [EW-1:0] evt_set = '0;
    logic        map_we = 1'b0, map_multi = 1'b0;
    logic [7:0]  map_addr = 8'h00, map_wdata = 8'h00;
    logic        map_held;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    acpi_ec_port uut (
        .clk(clk), .rst_n(rst_n),
        .host_cmd_wr(host_cmd_wr), .host_data_wr(host_data_wr),
        .host_data_rd(host_data_rd), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_status(host_status),
        .evt_set(evt_set), .map_we(map_we), .map_addr(map_addr),
        .map_wdata(map_wdata), .map_multi(map_multi), .map_held(map_held)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- behavioural reference model ----------------
    int         m_phase;            // 0 idle,1 decode,2 rd addr,3 rd fetch,4 wr addr,5 ack,6 wr val,7 commit
    bit         m_ibf, m_obf, m_last, m_burst, old_burst, acc_c, acc_d;
    logic [31:0] m_pend, clr;
    logic [7:0] m_rd, m_cmd, m_addr, m_val, m_test, m_comp;
    logic [7:0] m_rw [0:16];
    logic [7:0] m_map [0:223];

    function automatic logic [7:0] m_space(input logic [7:0] a);
        if (a == 8'h00) return 8'd2;
        if (a == 8'h01) return m_test;
        if (a == 8'h02) return m_comp;
        if (a >= 8'h03 && a <= 8'h13) return m_rw[a - 8'h03];
        if (a >= 8'h20) return m_map[a - 8'h20];
        return 8'h00;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_ibf = 0; m_obf = 0; m_last = 0; m_burst = 0;
            m_pend = 0; m_rd = 0; m_cmd = 0; m_addr = 0; m_val = 0;
            m_test = 0; m_comp = 8'hFF;
            for (int i = 0; i < 17; i++) m_rw[i] = 0;
            for (int i = 0; i < 224; i++) m_map[i] = 0;
        end else begin
            old_burst = m_burst;
            clr = 0;
            acc_c = host_cmd_wr && !m_ibf;
            acc_d = host_data_wr && !m_ibf && !host_cmd_wr &&
                    (m_phase == 2 || m_phase == 4 || m_phase == 6);
            if (host_data_rd) m_obf = 0;
            case (m_phase)
                1: begin
                    if (m_cmd == 8'h82) m_burst = 1;
                    if (m_cmd == 8'h83) m_burst = 0;
                    if (m_cmd == 8'h84) begin
                        m_rd = 0;
                        for (int i = 31; i >= 0; i--) if (m_pend[i]) m_rd = 8'(i + 1);
                        if (m_rd != 0) clr[m_rd - 1] = 1'b1;
                        m_obf = 1;
                    end
                    m_phase = (m_cmd == 8'h80) ? 2 : (m_cmd == 8'h81) ? 4 : 0;
                end
                2: if (acc_d) begin m_addr = host_wdata; m_phase = 3; end
                3: begin m_rd = m_space(m_addr); m_obf = 1; m_phase = 0; end
                4: if (acc_d) begin m_addr = host_wdata; m_phase = 5; end
                5: m_phase = 6;
                6: if (acc_d) begin m_val = host_wdata; m_phase = 7; end
                7: begin
                    if (m_addr == 8'h01) begin m_test = m_val; m_comp = 8'hFF - m_val; end
                    else if (m_addr >= 8'h03 && m_addr <= 8'h13) m_rw[m_addr - 8'h03] = m_val;
                    m_phase = 0;
                end
                default: ;
            endcase
            if (acc_c) begin m_phase = 1; m_cmd = host_wdata; end
            if (acc_c) m_last = 1; else if (acc_d) m_last = 0;
            m_ibf = acc_c || acc_d;
            m_pend = (m_pend & ~clr) | evt_set;
            if (map_we && !(old_burst && map_multi) && map_addr < 8'd224)
                m_map[map_addr] = map_wdata;
        end
    end

    function automatic logic [7:0] m_status();
        return {2'b00, |m_pend, m_burst, m_last, (m_phase != 0), m_ibf, m_obf};
    endfunction

    // compared on every clock
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (host_status !== m_status() || host_rdata !== m_rd) begin
                errors++;
                $display("FAIL R2 R7 cycle compare t=%0t: status=%h rdata=%h expected status=%h rdata=%h",
                         $time, host_status, host_rdata, m_status(), m_rd);
            end
        end
    end

    // ---------------- directed checks ----------------
    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic send_cmd(input logic [7:0] code);
        @(negedge clk); host_cmd_wr = 1; host_wdata = code;
        @(negedge clk); host_cmd_wr = 0;
    endtask

    task automatic wait_free();
        while (host_status[1]) @(negedge clk);
    endtask

    task automatic send_data(input logic [7:0] b);
        wait_free();
        host_data_wr = 1; host_wdata = b;
        @(negedge clk); host_data_wr = 0;
    endtask

    task automatic take_result(output logic [7:0] b);
        while (!host_status[0]) @(negedge clk);
        b = host_rdata;
        host_data_rd = 1;
        @(negedge clk); host_data_rd = 0;
    endtask

    task automatic acpi_rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
        logic [7:0] b;
        send_cmd(8'h80); wait_free();
        send_data(a);
        take_result(b);
        chk(tag, b, exp);
    endtask

    task automatic acpi_wr(input logic [7:0] a, input logic [7:0] v);
        send_cmd(8'h81); wait_free();
        send_data(a);
        send_data(v);
        repeat (3) @(negedge clk);
    endtask

    task automatic query(input logic [7:0] exp, input string tag);
        logic [7:0] b;
        send_cmd(8'h84);
        take_result(b);
        chk(tag, b, exp);
    endtask

    task automatic map_write(input logic [7:0] a, input logic [7:0] d, input bit multi);
        @(negedge clk); map_we = 1; map_addr = a; map_wdata = d; map_multi = multi;
        #1 chk("R8 map_held", {7'd0, map_held}, {7'd0, multi & host_status[4]});
        @(negedge clk); map_we = 0; map_multi = 0;
    endtask

    task automatic pulse_evt(input logic [EW-1:0] m);
        @(negedge clk); evt_set = m;
        @(negedge clk); evt_set = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R2 reset status", host_status, 8'h00);
        chk("R2 reset rdata", host_rdata, 8'h00);

        // R2 handshake timing
        @(negedge clk); host_cmd_wr = 1; host_wdata = 8'h80;
        @(negedge clk); host_cmd_wr = 0;
        chk("R2 busy+cmd flags", host_status & 8'h0E, 8'h0E);
        @(negedge clk);
        chk("R2 busy cleared", host_status[1], 1'b0);
        host_data_wr = 1; host_wdata = 8'h00;
        @(negedge clk); host_data_wr = 0;
        chk("R2 data clears last-cmd", host_status[3], 1'b0);
        @(negedge clk);
        chk("R2 ready", host_status[0], 1'b1);
        chk("R9 version", host_rdata, 8'd2);
        host_data_rd = 1; @(negedge clk); host_data_rd = 0;
        chk("R2 ready cleared", host_status[0], 1'b0);

        // R9 version read-only
        acpi_wr(8'h00, 8'h55);
        acpi_rd(8'h00, 8'd2, "R9 version after write");

        // R10 test byte and complement
        acpi_rd(8'h02, 8'hFF, "R10 complement reset");
        acpi_wr(8'h01, 8'h35);
        acpi_rd(8'h01, 8'h35, "R10 test byte");
        acpi_rd(8'h02, 8'hCA, "R10 complement");
        acpi_wr(8'h02, 8'h11);
        acpi_rd(8'h02, 8'hCA, "R10 complement write ignored");

        // R3 / R13 general registers
        acpi_wr(8'h03, 8'h5A);
        acpi_wr(8'h13, 8'hA7);
        acpi_rd(8'h03, 8'h5A, "R3 write low reg");
        acpi_rd(8'h13, 8'hA7, "R13 top reg");
        acpi_rd(8'h04, 8'h00, "R13 reset value");
        acpi_wr(8'h14, 8'h99);
        acpi_rd(8'h14, 8'h00, "R13 unmapped gap");

        // R11 mapped window
        map_write(8'h00, 8'hA1, 0);
        map_write(8'hDF, 8'h7E, 1);
        acpi_rd(8'h20, 8'hA1, "R11 first mapped");
        acpi_rd(8'hFF, 8'h7E, "R11 last mapped");
        acpi_wr(8'h20, 8'h00);
        acpi_rd(8'h20, 8'hA1, "R11 host write ignored");

        // R7 / R8 burst mode
        send_cmd(8'h82); repeat (2) @(negedge clk);
        chk("R7 burst on", host_status[4], 1'b1);
        map_write(8'h05, 8'h33, 1);
        map_write(8'h06, 8'h44, 0);
        acpi_rd(8'h25, 8'h00, "R8 multi held");
        acpi_rd(8'h26, 8'h44, "R8 single lands");
        send_cmd(8'h83); repeat (2) @(negedge clk);
        chk("R7 burst off", host_status[4], 1'b0);
        map_write(8'h05, 8'h33, 1);
        acpi_rd(8'h25, 8'h33, "R8 multi after burst");

        // R4 / R6 events
        query(8'h00, "R4 empty query");
        pulse_evt(32'h8000_0008);
        @(negedge clk);
        chk("R6 sci set", host_status[5], 1'b1);
        query(8'd4, "R4 lowest first");
        query(8'd32, "R4 bit 31");
        @(negedge clk);
        chk("R6 sci cleared", host_status[5], 1'b0);
        query(8'h00, "R4 drained");

        // R5 same-cycle set and pop
        pulse_evt(32'h0000_0001);
        @(negedge clk); host_cmd_wr = 1; host_wdata = 8'h84;
        @(negedge clk); host_cmd_wr = 0; evt_set = 32'h1;
        @(negedge clk); evt_set = '0;
        begin
            logic [7:0] b;
            take_result(b);
            chk("R5 popped index", b, 8'd1);
        end
        chk("R5 bit kept", host_status[5], 1'b1);
        query(8'd1, "R5 bit still pending");
        query(8'd0, "R5 now empty");

        // R1 unknown command
        send_cmd(8'h90); @(negedge clk);
        chk("R1 unknown idle", host_status & 8'h37, 8'h00);
        acpi_rd(8'h03, 8'h5A, "R1 state intact");

        // R12 stray data write
        @(negedge clk); host_data_wr = 1; host_wdata = 8'h42;
        @(negedge clk); host_data_wr = 0;
        chk("R12 stray data ignored", host_status, 8'h00);

        repeat (3) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, got hang expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule